// File: doc/BRIEF.md
# Periodic Coprocessor Restart Timer

This block restarts a small coprocessor's program at regular intervals. Once the core signals that it has halted, the timer counts clock ticks. When the count reaches the selected period, the timer issues a one-cycle start pulse, and the stored entry address accompanies it. The block holds a bank of five period registers. A select register picks which period is in use. The running program can change that selection by executing its sleep instruction, which the core forwards here as a select-update strobe carrying a 4-bit index.

Software configures the block through a simple write port. That port carries the five periods, the entry address and a control word. The control word has an enable bit, which gates every restart. It also has a run bit, which starts the program at once and sets the enable. A halt leaves the timer armed, so the program keeps coming back. Clearing the enable stops any further restarts but does not touch a program that is already running. Converting a time interval into a tick count is left to software.

Top module: `cp_restart_timer`

## Requirements
- R1: After a synchronous reset, `start_pulse` and `start_addr` are 0, the enable is clear, and period slot 0 is selected.
- R2: A write with `cfg_addr` 0..4 loads period slot 0..4, `cfg_addr` 5 loads the entry address, and `cfg_addr` 6 writes the control word (bit 0 enable, bit 1 run command).
- R3: With the enable set, a `core_halt` sampled at clock edge H produces `start_pulse` from edge H+P, where P is the selected period. `start_addr` then shows the entry address.
- R4: The period in use is the slot named by the select register.
- R5: A `sel_upd` strobe with an index of 0..4 changes the select register, and later restarts use the new slot.
- R6: A `sel_upd` strobe with an index of 5 or more is ignored, and the previous selection stays in force.
- R7: While the core runs (no halt pending), the counter stays idle and no start pulse is produced. Each halt yields at most one pulse.
- R8: While the enable is clear, no restart is issued. This holds for a pending count that the clear interrupts and for halts that arrive while disabled.
- R9: A control write with the run bit set produces `start_pulse` on the next edge with the entry address, and sets the enable.
- R10: A period value of 0 behaves like a period of 1.
- R11: `start_pulse` is high for exactly one cycle per restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| core_halt | input | 1 | One-cycle strobe: core has halted |
| sel_upd | input | 1 | One-cycle strobe: sleep instruction executed |
| sel_upd_idx | input | 4 | Period index carried by the sleep instruction |
| start_pulse | output | 1 | One-cycle program start request |
| start_addr | output | 11 | Entry address given with the start request |

## Verification
On every cycle, the embedded assertions check several invariants. The select register never holds an index outside the bank, and an out-of-range update leaves it untouched. The counter rests at zero whenever no halt is pending. No pulse follows a cycle in which the enable was clear without a run command, and a pulse never repeats on the next cycle unless a run command asked for it. Only the directed scenarios can show the exact restart latency for each period slot, the effect of a mid-program select change on the following restart, the entry address travelling with the pulse, and that restarts recover after a run command.

// File: rtl/cp_rt_pkg.sv
package cp_rt_pkg;
  // control word bit positions
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_RUN_BIT = 1;
  // width of the index field carried by the sleep instruction
  localparam int unsigned SEL_FIELD_W  = 4;

  typedef enum logic [1:0] {
    CNT_IDLE  = 2'd0,
    CNT_ARMED = 2'd1
  } cnt_state_e;
endpackage

// File: rtl/cp_rt_cfg.sv
module cp_rt_cfg #(
  parameter int unsigned NPER   = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0]  period_q [NPER],
  output logic [ADDR_W-1:0] entry_q,
  output logic              enable_q,
  output logic              run_cmd
);
  import cp_rt_pkg::*;

  localparam logic [REG_AW-1:0] ENTRY_ADDR = REG_AW'(NPER);
  localparam logic [REG_AW-1:0] CTRL_ADDR  = REG_AW'(NPER + 1);

  logic ctrl_wr;
  assign ctrl_wr = cfg_we && (cfg_addr == CTRL_ADDR);
  assign run_cmd = ctrl_wr && cfg_wdata[CTRL_RUN_BIT];

  for (genvar i = 0; i < NPER; i++) begin : g_period
    always_ff @(posedge clk) begin
      if (rst)
        period_q[i] <= '0;
      else if (cfg_we && cfg_addr == REG_AW'(i))
        period_q[i] <= cfg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q  <= '0;
      enable_q <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == ENTRY_ADDR)
        entry_q <= cfg_wdata[ADDR_W-1:0];
      if (ctrl_wr)
        enable_q <= cfg_wdata[CTRL_EN_BIT] | cfg_wdata[CTRL_RUN_BIT];
    end
  end

  // run command always leaves the enable set (R9)
  assert_run_sets_enable_R9: assert property (@(posedge clk) disable iff (rst)
    run_cmd |=> enable_q);
endmodule

// File: rtl/cp_rt_sel.sv
module cp_rt_sel #(
  parameter int unsigned NPER  = 5,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [IDX_W-1:0] upd_idx,
  output logic [SEL_W-1:0] sel_q
);
  logic idx_ok;
  assign idx_ok = 32'(upd_idx) < NPER;

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= '0;
    else if (upd && idx_ok)
      sel_q <= upd_idx[SEL_W-1:0];
  end

  assert_sel_in_bank_R4: assert property (@(posedge clk) disable iff (rst)
    32'(sel_q) < NPER);

  assert_bad_index_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (upd && 32'(upd_idx) >= NPER) |=> $stable(sel_q));
endmodule

// File: rtl/cp_rt_count.sv
module cp_rt_count #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              run_cmd,
  input  logic              core_halt,
  input  logic [CNT_W-1:0]  period,
  input  logic [ADDR_W-1:0] entry,
  output logic              start_pulse,
  output logic [ADDR_W-1:0] start_addr
);
  import cp_rt_pkg::*;

  cnt_state_e         state_q;
  logic [CNT_W-1:0]   count_q;
  logic               fire;

  // period 0 fires like period 1 (R10)
  assign fire = ({1'b0, count_q} + (CNT_W+1)'(1)) >= {1'b0, period};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= CNT_IDLE;
      count_q     <= '0;
      start_pulse <= 1'b0;
      start_addr  <= '0;
    end else begin
      start_pulse <= 1'b0;
      if (run_cmd) begin
        start_pulse <= 1'b1;
        start_addr  <= entry;
        state_q     <= CNT_IDLE;
        count_q     <= '0;
      end else if (!enable) begin
        state_q <= CNT_IDLE;
        count_q <= '0;
      end else if (core_halt) begin
        state_q <= CNT_ARMED;
        count_q <= '0;
      end else if (state_q == CNT_ARMED) begin
        if (fire) begin
          start_pulse <= 1'b1;
          start_addr  <= entry;
          state_q     <= CNT_IDLE;
          count_q     <= '0;
        end else begin
          count_q <= count_q + CNT_W'(1);
        end
      end
    end
  end

  assert_idle_counter_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == CNT_IDLE) |-> (count_q == '0));

  assert_pulse_disarms_R7: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> (state_q == CNT_IDLE));

  assert_no_restart_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!enable && !run_cmd) |=> !start_pulse);

  assert_single_cycle_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> (!start_pulse || $past(run_cmd)));
endmodule

// File: rtl/cp_restart_timer.sv
module cp_restart_timer #(
  parameter int unsigned NPER   = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned IDX_W  = cp_rt_pkg::SEL_FIELD_W,
  parameter int unsigned DATA_W = (CNT_W > ADDR_W) ? CNT_W : ADDR_W,
  parameter int unsigned REG_AW = $clog2(NPER + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              core_halt,
  input  logic              sel_upd,
  input  logic [IDX_W-1:0]  sel_upd_idx,
  output logic              start_pulse,
  output logic [ADDR_W-1:0] start_addr
);
  localparam int unsigned SEL_W = (NPER > 1) ? $clog2(NPER) : 1;

  logic [CNT_W-1:0]  period_q [NPER];
  logic [ADDR_W-1:0] entry_q;
  logic              enable_q;
  logic              run_cmd;
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  period_sel;

  cp_rt_cfg #(
    .NPER(NPER), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) i_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .period_q(period_q), .entry_q(entry_q),
    .enable_q(enable_q), .run_cmd(run_cmd)
  );

  cp_rt_sel #(
    .NPER(NPER), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) i_sel (
    .clk(clk), .rst(rst),
    .upd(sel_upd), .upd_idx(sel_upd_idx),
    .sel_q(sel_q)
  );

  assign period_sel = period_q[sel_q];

  cp_rt_count #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) i_count (
    .clk(clk), .rst(rst),
    .enable(enable_q), .run_cmd(run_cmd), .core_halt(core_halt),
    .period(period_sel), .entry(entry_q),
    .start_pulse(start_pulse), .start_addr(start_addr)
  );
endmodule

// File: tb/test_cp_restart_timer.sv
module test_cp_restart_timer;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        core_halt;
  logic        sel_upd;
  logic [3:0]  sel_upd_idx;
  logic        start_pulse;
  logic [10:0] start_addr;

  int applied = 0;
  int miscmp  = 0;
  int cyc     = 0;
  int pulse_cnt = 0;
  int last_pulse_cyc = -1;
  logic [10:0] last_addr = '0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cp_restart_timer i_cp_restart_timer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .core_halt(core_halt), .sel_upd(sel_upd),
    .sel_upd_idx(sel_upd_idx), .start_pulse(start_pulse), .start_addr(start_addr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && start_pulse) begin
      pulse_cnt      <= pulse_cnt + 1;
      last_pulse_cyc <= cyc;
      last_addr      <= start_addr;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    applied++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sel(input logic [3:0] idx);
    @(negedge clk);
    sel_upd = 1'b1; sel_upd_idx = idx;
    @(negedge clk);
    sel_upd = 1'b0;
  endtask

  // halt, then expect exactly one pulse P cycles after the sampling edge
  task automatic halt_expect(input int p, input logic [10:0] addr, input string tag);
    int c0, k;
    @(negedge clk);
    c0 = pulse_cnt; k = cyc;
    core_halt = 1'b1;
    @(negedge clk);
    core_halt = 1'b0;
    repeat (p + 4) @(negedge clk);
    check(pulse_cnt == c0 + 1, {tag, " pulse count"}, pulse_cnt - c0, 1);
    check(last_pulse_cyc == k + 1 + p, {tag, " latency"}, last_pulse_cyc - k - 1, p);
    check(last_addr == addr, {tag, " entry address"}, int'(last_addr), int'(addr));
  endtask

  task automatic quiet(input int n, input string tag);
    int c0;
    c0 = pulse_cnt;
    repeat (n) @(negedge clk);
    check(pulse_cnt == c0, tag, pulse_cnt - c0, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(start_pulse == 1'b0, "R1 pulse low after reset", int'(start_pulse), 0);
    check(start_addr == '0, "R1 address zero after reset", int'(start_addr), 0);
    // enable clear: a halt yields nothing
    @(negedge clk); core_halt = 1'b1;
    @(negedge clk); core_halt = 1'b0;
    quiet(20, "R1 disabled after reset");
  endtask

  task automatic t_config_and_run;
    int k, c0;
    wr(3'd0, 16'd5); wr(3'd1, 16'd9); wr(3'd2, 16'd3);
    wr(3'd3, 16'd12); wr(3'd4, 16'd7); wr(3'd5, 16'h02A);
    @(negedge clk);
    c0 = pulse_cnt; k = cyc;
    cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 16'h0002; // run bit only
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    check(pulse_cnt == c0 + 1, "R9 run pulse count", pulse_cnt - c0, 1);
    check(last_pulse_cyc == k + 1, "R9 run pulse next cycle", last_pulse_cyc - k, 1);
    check(last_addr == 11'h02A, "R2 R9 entry address", int'(last_addr), 'h2A);
  endtask

  task automatic t_default_slot;
    halt_expect(5, 11'h02A, "R3 R4 slot0");
    quiet(30, "R7 no pulse while running");
    halt_expect(5, 11'h02A, "R3 periodic second halt");
  endtask

  task automatic t_select;
    sel(4'd2);  halt_expect(3, 11'h02A, "R5 slot2");
    sel(4'd4);  halt_expect(7, 11'h02A, "R5 slot4");
    sel(4'd1);  halt_expect(9, 11'h02A, "R5 slot1");
    sel(4'd3);  halt_expect(12, 11'h02A, "R5 slot3");
  endtask

  task automatic t_bad_select;
    sel(4'd5);  halt_expect(12, 11'h02A, "R6 index5 ignored");
    sel(4'd15); halt_expect(12, 11'h02A, "R6 index15 ignored");
  endtask

  task automatic t_entry_and_zero;
    wr(3'd5, 16'h1F3);
    sel(4'd0);
    wr(3'd0, 16'd0);
    halt_expect(1, 11'h1F3, "R10 period zero");
    wr(3'd0, 16'd1);
    halt_expect(1, 11'h1F3, "R10 period one");
  endtask

  task automatic t_disable;
    wr(3'd0, 16'd8);
    @(negedge clk); core_halt = 1'b1;
    @(negedge clk); core_halt = 1'b0;
    wr(3'd6, 16'h0000);
    quiet(30, "R8 pending count cancelled");
    @(negedge clk); core_halt = 1'b1;
    @(negedge clk); core_halt = 1'b0;
    quiet(30, "R8 halt while disabled");
    t_rerun();
  endtask

  task automatic t_rerun;
    int c0;
    c0 = pulse_cnt;
    wr(3'd6, 16'h0002);
    repeat (2) @(negedge clk);
    check(pulse_cnt == c0 + 1, "R9 rerun pulse", pulse_cnt - c0, 1);
    halt_expect(8, 11'h1F3, "R9 restarts re-enabled");
  endtask

  task automatic t_pulse_width;
    int hi;
    hi = 0;
    @(negedge clk); core_halt = 1'b1;
    @(negedge clk); core_halt = 1'b0;
    repeat (14) begin
      @(negedge clk);
      if (start_pulse) hi++;
    end
    check(hi == 1, "R11 pulse one cycle wide", hi, 1);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    core_halt = 1'b0; sel_upd = 1'b0; sel_upd_idx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_config_and_run();
    t_default_slot();
    t_select();
    t_bad_select();
    t_entry_and_zero();
    t_disable();
    t_pulse_width();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      applied++;
      miscmp++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end
endmodule